// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Pending Queue

This block keeps the log for uncorrectable errors: a first-error pointer, a four-word header log, a four-word prefix log with a prefix-present flag, and the source identifier of the logged error. It also owns the uncorrectable status register, which software clears by writing ones. When multiple-header recording is enabled and the error currently in the log has not been cleared yet, new error records wait in a FIFO. A record leaves the FIFO and enters the log only when software clears the status bit the pointer names.

An upstream classifier presents one record per cycle on the record port. Each record carries a one-hot status bit, a source identifier, header and prefix valid flags, and the header and prefix words. Software status writes arrive on the write port as a clear mask. The recording enable comes from the capability and control register, and the block reports back whether it can record multiple headers at all. The queue depth is a parameter of 0 to 32 entries.

Top module: `mh_err_log`

## Requirements
- R1: `mhr_cap_o` is 1 exactly when DEPTH is greater than zero. While recording is off (`mhr_en_i` low or DEPTH zero), every record goes straight into the log, whatever the status bit at the pointer holds.
- R2: A record that goes straight into the log sets `first_ptr_o` to the index of its single status bit and sets that bit in `sts_o`. It also sets `src_log_o` to its source identifier. All of these show on the clock edge that ends the request cycle. Status bit 0 is reserved, so records use bits 1 and up.
- R3: On a direct load, `hdr_log_o` takes the record's header words if the header-valid flag is set. Otherwise it becomes all zero.
- R4: `pfx_log_o` takes the record's prefix words, and `pfx_present_o` is set, only when both the record's prefix-valid flag and `pfx_sup_i` are 1. Otherwise the prefix log is zero and `pfx_present_o` is 0.
- R5: While recording is on and the status bit at the pointer is set, a new record is appended to the queue. `pend_cnt_o` rises by one, and the log outputs and pointer stay unchanged. The record's status bit is still set in `sts_o`.
- R6: A record that would be appended to a full queue is dropped. `ovf_o` is high for the one cycle after the request, and `pend_cnt_o` stays at DEPTH.
- R7: A write that clears the pointed-to status bit while recording is on and the queue is not empty moves the oldest queued record into the log, in FIFO order. It also sets again the status bits of every record that was queued before the write.
- R8: A write that clears the pointed-to status bit while the queue is empty or recording is off clears the pointer, the header, prefix and source logs, and `pfx_present_o`.
- R9: Status writes are write-one-to-clear. A write that leaves the pointed-to bit set while recording is on restores any status bit of a queued record that the write cleared. Other bits clear as written.
- R10: While recording is off, the queue is emptied, and `pend_cnt_o` reads 0 one cycle later.
- R11: A status write and a record in the same cycle: the write is applied first, including any promotion or clear, and the record is then judged against the resulting status and pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mhr_en_i | input | 1 | Multiple-header recording enable |
| pfx_sup_i | input | 1 | End-to-end prefix support advertised |
| rec_valid_i | input | 1 | Error record request |
| rec_status_i | input | STAT_W | One-hot uncorrectable status bit of the record |
| rec_src_i | input | SRC_W | Source identifier of the record |
| rec_hdr_vld_i | input | 1 | Record header words are valid |
| rec_pfx_vld_i | input | 1 | Record prefix words are present |
| rec_hdr_i | input | LOG_W | Four header words, word 0 in the low bits |
| rec_pfx_i | input | LOG_W | Four prefix words, word 0 in the low bits |
| sts_wr_i | input | 1 | Software write to the status register |
| sts_wdata_i | input | STAT_W | Write-one-to-clear mask |
| sts_o | output | STAT_W | Uncorrectable status register |
| first_ptr_o | output | PTR_W | First error pointer |
| hdr_log_o | output | LOG_W | Header log |
| pfx_log_o | output | LOG_W | Prefix log |
| pfx_present_o | output | 1 | Prefix log holds a valid prefix |
| src_log_o | output | SRC_W | Source identifier of the logged error |
| pend_cnt_o | output | CNT_W | Number of queued records |
| ovf_o | output | 1 | Record dropped on a full queue |
| mhr_cap_o | output | 1 | Multiple-header recording capability |

## Verification
The bench fills the queue to the last slot and then one past it. A design that compares against the wrong count would either drop a record that fits or overwrite the oldest entry. Clearing a queued record's status bit early while the logged bit stays set checks the restore. A design that skipped it would leave that bit clear, and the record would be promoted later with no status behind it. Draining the queue in order catches any departure from FIFO promotion, and the final clear must zero every log field. The bench also checks records without a header or with prefixes that are not advertised, since these must zero their fields and not keep stale words. It covers the flush when recording is turned off, with the direct load that follows. Last, it puts a clearing write and a new record in the same cycle: a design that judged the record before the write would load it over the promoted error and not queue it.

// File: rtl/erl_pkg.sv
package erl_pkg;
  parameter int unsigned STAT_W    = 32;
  parameter int unsigned WORD_W    = 32;
  parameter int unsigned LOG_WORDS = 4;
  parameter int unsigned SRC_W     = 16;
  localparam int unsigned PTR_W    = $clog2(STAT_W);
  localparam int unsigned LOG_W    = WORD_W * LOG_WORDS;

  typedef struct packed {
    logic [STAT_W-1:0] sts;
    logic [SRC_W-1:0]  src;
    logic              hdr_vld;
    logic              pfx_vld;
    logic [LOG_W-1:0]  hdr;
    logic [LOG_W-1:0]  pfx;
  } err_rec_t;

  function automatic logic [PTR_W-1:0] bit_index(logic [STAT_W-1:0] v);
    logic [PTR_W-1:0] r;
    r = '0;
    for (int i = STAT_W - 1; i >= 0; i--) begin
      if (v[i]) r = PTR_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/erl_fifo.sv
module erl_fifo
  import erl_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  err_rec_t         wdata_i,
  output err_rec_t         head_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic [STAT_W-1:0] pend_o
);
  if (DEPTH == 0) begin : g_none
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, flush_i, push_i, pop_i, wdata_i};
    assign head_o = '0;
    assign cnt_o  = '0;
    assign full_o = 1'b1;
    assign pend_o = '0;
  end else begin : g_q
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    err_rec_t         mem_q [DEPTH];
    logic [IDX_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [IDX_W-1:0] nxt(logic [IDX_W-1:0] p);
      return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q  <= '0;
        wr_q  <= '0;
        cnt_q <= '0;
      end else if (flush_i) begin
        rd_q  <= '0;
        wr_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (push_i) wr_q <= nxt(wr_q);
        if (pop_i)  rd_q <= nxt(rd_q);
        if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
        else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (push_i && !flush_i) mem_q[wr_q] <= wdata_i;
    end

    // status bits of every queued record
    always_comb begin
      pend_o = '0;
      for (int k = 0; k < DEPTH; k++) begin
        if (CNT_W'(k) < cnt_q)
          pend_o |= mem_q[IDX_W'((int'(rd_q) + k) % DEPTH)].sts;
      end
    end

    assign head_o = mem_q[rd_q];
    assign cnt_o  = cnt_q;
    assign full_o = (cnt_q == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i && !pop_i |-> cnt_q < CNT_W'(DEPTH)); // R6
    AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i |-> cnt_q != '0); // R7
  end
endmodule

// File: rtl/erl_log.sv
module erl_log
  import erl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clr_i,
  input  err_rec_t         rec_i,
  input  logic             pfx_sup_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [LOG_W-1:0] hdr_o,
  output logic [LOG_W-1:0] pfx_o,
  output logic             pp_o,
  output logic [SRC_W-1:0] src_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [LOG_W-1:0] hdr_q, pfx_q;
  logic             pp_q;
  logic [SRC_W-1:0] src_q;
  logic             pp_d;

  assign pp_d = rec_i.pfx_vld & pfx_sup_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      hdr_q <= '0;
      pfx_q <= '0;
      pp_q  <= 1'b0;
      src_q <= '0;
    end else if (load_i) begin
      ptr_q <= bit_index(rec_i.sts);
      hdr_q <= rec_i.hdr_vld ? rec_i.hdr : '0;
      pfx_q <= pp_d ? rec_i.pfx : '0;
      pp_q  <= pp_d;
      src_q <= rec_i.src;
    end else if (clr_i) begin
      ptr_q <= '0;
      hdr_q <= '0;
      pfx_q <= '0;
      pp_q  <= 1'b0;
      src_q <= '0;
    end
  end

  assign ptr_o = ptr_q;
  assign hdr_o = hdr_q;
  assign pfx_o = pfx_q;
  assign pp_o  = pp_q;
  assign src_o = src_q;

  AST_PFX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pp_q |-> pfx_q == '0); // R4
  AST_CLR_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !load_i |=> ptr_q == '0 && hdr_q == '0 && !pp_q); // R8
endmodule

// File: rtl/mh_err_log.sv
module mh_err_log
  import erl_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mhr_en_i,
  input  logic              pfx_sup_i,
  input  logic              rec_valid_i,
  input  logic [STAT_W-1:0] rec_status_i,
  input  logic [SRC_W-1:0]  rec_src_i,
  input  logic              rec_hdr_vld_i,
  input  logic              rec_pfx_vld_i,
  input  logic [LOG_W-1:0]  rec_hdr_i,
  input  logic [LOG_W-1:0]  rec_pfx_i,
  input  logic              sts_wr_i,
  input  logic [STAT_W-1:0] sts_wdata_i,
  output logic [STAT_W-1:0] sts_o,
  output logic [PTR_W-1:0]  first_ptr_o,
  output logic [LOG_W-1:0]  hdr_log_o,
  output logic [LOG_W-1:0]  pfx_log_o,
  output logic              pfx_present_o,
  output logic [SRC_W-1:0]  src_log_o,
  output logic [CNT_W-1:0]  pend_cnt_o,
  output logic              ovf_o,
  output logic              mhr_cap_o
);
  localparam logic CAP = (DEPTH > 0);

  err_rec_t          rec_in, head, load_rec;
  logic [STAT_W-1:0] sts_q, sts_w, sts_n, pend;
  logic [PTR_W-1:0]  ptr_q, ptr_mid;
  logic [CNT_W-1:0]  cnt;
  logic              en, full, push, pop, log_load, log_clr, ovf_q, ovf_n;

  assign en = mhr_en_i & CAP;

  assign rec_in = '{sts: rec_status_i, src: rec_src_i, hdr_vld: rec_hdr_vld_i,
                    pfx_vld: rec_pfx_vld_i, hdr: rec_hdr_i, pfx: rec_pfx_i};

  // write first, then judge the record against the result
  always_comb begin
    sts_w    = sts_q & ~(sts_wr_i ? sts_wdata_i : '0);
    sts_n    = sts_w;
    ptr_mid  = ptr_q;
    pop      = 1'b0;
    push     = 1'b0;
    log_load = 1'b0;
    log_clr  = 1'b0;
    load_rec = head;
    ovf_n    = 1'b0;
    if (sts_wr_i) begin
      if (!sts_w[ptr_q]) begin
        if (en && cnt != '0) begin
          pop      = 1'b1;
          log_load = 1'b1;
          sts_n    = sts_w | pend;
          ptr_mid  = bit_index(head.sts);
        end else begin
          log_clr = 1'b1;
          ptr_mid = '0;
        end
      end else if (en) begin
        sts_n = sts_w | pend;
      end
    end
    if (rec_valid_i) begin
      if (en && sts_n[ptr_mid]) begin
        if (full && !pop) ovf_n = 1'b1;
        else              push  = 1'b1;
      end else begin
        log_load = 1'b1;
        log_clr  = 1'b0;
        load_rec = rec_in;
      end
      sts_n = sts_n | rec_status_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      sts_q <= sts_n;
      ovf_q <= ovf_n;
    end
  end

  erl_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!en),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (rec_in),
    .head_o  (head),
    .cnt_o   (cnt),
    .full_o  (full),
    .pend_o  (pend)
  );

  erl_log u_log (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (log_load),
    .clr_i     (log_clr),
    .rec_i     (load_rec),
    .pfx_sup_i (pfx_sup_i),
    .ptr_o     (ptr_q),
    .hdr_o     (hdr_log_o),
    .pfx_o     (pfx_log_o),
    .pp_o      (pfx_present_o),
    .src_o     (src_log_o)
  );

  assign sts_o       = sts_q;
  assign first_ptr_o = ptr_q;
  assign pend_cnt_o  = cnt;
  assign ovf_o       = ovf_q;
  assign mhr_cap_o   = CAP;

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> cnt == '0); // R10
  AST_OVF_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> cnt == CNT_W'(DEPTH)); // R6
  AST_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_i && en && sts_w[ptr_q] && !rec_valid_i |=> (sts_q & $past(pend)) == $past(pend)); // R9
  AST_DIRECT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && !(en && sts_n[ptr_mid]) |=> sts_q[ptr_q]); // R2
  AST_QUEUE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && !sts_wr_i && en && sts_q[ptr_q] |=> $stable(ptr_q)); // R5
endmodule

// File: tb/mh_err_log_tb_top.sv
module mh_err_log_tb_top;
  import erl_pkg::*;

  localparam int unsigned DEPTH = 4;
  localparam int unsigned CNT_W = $clog2(DEPTH + 2);

  typedef struct packed {
    logic        op;      // 0 record, 1 status write
    logic [31:0] arg;     // record: bit index; write: clear mask
    logic [7:0]  e_ptr;
    logic [7:0]  e_cnt;
    logic [31:0] e_sts;
    logic        e_ovf;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'd4,     8'd4, 8'd0, 32'h010, 1'b0}, // R2 direct
    '{1'b0, 32'd5,     8'd4, 8'd1, 32'h030, 1'b0}, // R5 queue
    '{1'b0, 32'd6,     8'd4, 8'd2, 32'h070, 1'b0},
    '{1'b0, 32'd7,     8'd4, 8'd3, 32'h0F0, 1'b0},
    '{1'b0, 32'd8,     8'd4, 8'd4, 32'h1F0, 1'b0},
    '{1'b0, 32'd9,     8'd4, 8'd4, 32'h3F0, 1'b1}, // R6 overflow
    '{1'b1, 32'h020,   8'd4, 8'd4, 32'h3F0, 1'b0}, // R9 restore
    '{1'b1, 32'h200,   8'd4, 8'd4, 32'h1F0, 1'b0}, // R9 plain clear
    '{1'b1, 32'h010,   8'd5, 8'd3, 32'h1E0, 1'b0}, // R7 promote
    '{1'b1, 32'h020,   8'd6, 8'd2, 32'h1C0, 1'b0},
    '{1'b1, 32'h040,   8'd7, 8'd1, 32'h180, 1'b0},
    '{1'b1, 32'h080,   8'd8, 8'd0, 32'h100, 1'b0},
    '{1'b1, 32'h100,   8'd0, 8'd0, 32'h000, 1'b0}  // R8 clear
  };

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              mhr_en, pfx_sup, rec_valid, hdr_vld, pfx_vld, sts_wr;
  logic [STAT_W-1:0] rec_status, sts_wdata, sts;
  logic [SRC_W-1:0]  rec_src, src_log;
  logic [LOG_W-1:0]  rec_hdr, rec_pfx, hdr_log, pfx_log;
  logic [PTR_W-1:0]  ptr;
  logic              pp, ovf, cap;
  logic [CNT_W-1:0]  cnt;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mh_err_log #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mhr_en_i(mhr_en), .pfx_sup_i(pfx_sup),
    .rec_valid_i(rec_valid), .rec_status_i(rec_status), .rec_src_i(rec_src),
    .rec_hdr_vld_i(hdr_vld), .rec_pfx_vld_i(pfx_vld), .rec_hdr_i(rec_hdr),
    .rec_pfx_i(rec_pfx), .sts_wr_i(sts_wr), .sts_wdata_i(sts_wdata),
    .sts_o(sts), .first_ptr_o(ptr), .hdr_log_o(hdr_log), .pfx_log_o(pfx_log),
    .pfx_present_o(pp), .src_log_o(src_log), .pend_cnt_o(cnt), .ovf_o(ovf),
    .mhr_cap_o(cap)
  );

  function automatic logic [LOG_W-1:0] hdr_of(int idx);
    logic [LOG_W-1:0] r;
    for (int k = 0; k < LOG_WORDS; k++) r[k*WORD_W +: WORD_W] = 32'hC0DE0000 | (idx << 4) | k;
    return r;
  endfunction

  function automatic logic [LOG_W-1:0] pfx_of(int idx);
    logic [LOG_W-1:0] r;
    for (int k = 0; k < LOG_WORDS; k++) r[k*WORD_W +: WORD_W] = 32'hF00D0000 | (idx << 4) | k;
    return r;
  endfunction

  task automatic chk(string what, logic [LOG_W-1:0] act, logic [LOG_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic set_rec(int idx, logic hv, logic pv);
    rec_valid  = 1'b1;
    rec_status = STAT_W'(1) << idx;
    rec_src    = SRC_W'(16'h100 + idx);
    hdr_vld    = hv;
    pfx_vld    = pv;
    rec_hdr    = hdr_of(idx);
    rec_pfx    = pfx_of(idx);
  endtask

  task automatic idle();
    rec_valid = 1'b0; sts_wr = 1'b0; sts_wdata = '0; rec_status = '0;
  endtask

  task automatic do_rec(int idx, logic hv, logic pv);
    @(negedge clk); set_rec(idx, hv, pv);
    @(negedge clk); idle();
  endtask

  task automatic do_wr(logic [STAT_W-1:0] m);
    @(negedge clk); sts_wr = 1'b1; sts_wdata = m;
    @(negedge clk); idle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    mhr_en = 1'b1; pfx_sup = 1'b1; hdr_vld = 1'b0; pfx_vld = 1'b0;
    rec_src = '0; rec_hdr = '0; rec_pfx = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cap", LOG_W'(cap), 1);
    chk("R2 reset ptr", LOG_W'(ptr), 0);
    chk("R2 reset sts", LOG_W'(sts), 0);
    chk("R5 reset cnt", LOG_W'(cnt), 0);
    chk("R6 reset ovf", LOG_W'(ovf), 0);
    chk("R4 reset pp", LOG_W'(pp), 0);
    chk("R3 reset hdr", hdr_log, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].op) do_wr(VEC[v].arg);
      else do_rec(int'(VEC[v].arg), 1'b1, 1'b1);
      chk(VEC[v].op ? "R7/R8/R9 vec ptr" : "R2/R5/R6 vec ptr", LOG_W'(ptr), LOG_W'(VEC[v].e_ptr));
      chk(VEC[v].op ? "R7/R8/R9 vec cnt" : "R2/R5/R6 vec cnt", LOG_W'(cnt), LOG_W'(VEC[v].e_cnt));
      chk(VEC[v].op ? "R7/R8/R9 vec sts" : "R2/R5/R6 vec sts", LOG_W'(sts), LOG_W'(VEC[v].e_sts));
      chk("R6 vec ovf", LOG_W'(ovf), LOG_W'(VEC[v].e_ovf));
      chk("R3 vec hdr", hdr_log, (VEC[v].e_ptr != 0) ? hdr_of(VEC[v].e_ptr) : '0);
      chk("R4 vec pfx", pfx_log, (VEC[v].e_ptr != 0) ? pfx_of(VEC[v].e_ptr) : '0);
      chk("R4 vec pp", LOG_W'(pp), LOG_W'(VEC[v].e_ptr != 0));
      chk("R2 vec src", LOG_W'(src_log), (VEC[v].e_ptr != 0) ? LOG_W'(16'h100 + VEC[v].e_ptr) : '0);
    end

    // R3 / R4: no header, prefix not advertised
    pfx_sup = 1'b0;
    do_rec(3, 1'b0, 1'b1);
    chk("R3 no hdr ptr", LOG_W'(ptr), 3);
    chk("R3 no hdr zero", hdr_log, 0);
    chk("R4 unsupported pfx zero", pfx_log, 0);
    chk("R4 unsupported pp", LOG_W'(pp), 0);
    do_wr(32'h8);
    pfx_sup = 1'b1;
    do_rec(2, 1'b1, 1'b0);
    chk("R4 absent pfx pp", LOG_W'(pp), 0);
    chk("R3 hdr loaded", hdr_log, hdr_of(2));
    do_wr(32'h4);
    chk("R8 cleared ptr", LOG_W'(ptr), 0);

    // R10 flush, R1 direct load while disabled
    do_rec(10, 1'b1, 1'b1);
    do_rec(11, 1'b1, 1'b1);
    chk("R5 queued one", LOG_W'(cnt), 1);
    @(negedge clk); mhr_en = 1'b0;
    @(negedge clk);
    chk("R10 flushed", LOG_W'(cnt), 0);
    do_rec(12, 1'b1, 1'b1);
    chk("R1 direct while off ptr", LOG_W'(ptr), 12);
    chk("R1 direct while off cnt", LOG_W'(cnt), 0);
    chk("R1 sts", LOG_W'(sts), 32'h1C00);
    do_wr(32'h1000);
    chk("R8 off clear ptr", LOG_W'(ptr), 0);
    chk("R8 off clear hdr", hdr_log, 0);
    chk("R9 off sts", LOG_W'(sts), 32'hC00);
    do_wr(32'hC00);
    mhr_en = 1'b1;

    // R11 write and record in one cycle
    do_rec(13, 1'b1, 1'b1);
    do_rec(14, 1'b1, 1'b1);
    @(negedge clk); set_rec(15, 1'b1, 1'b1); sts_wr = 1'b1; sts_wdata = 32'h2000;
    @(negedge clk); idle();
    chk("R11 ptr", LOG_W'(ptr), 14);
    chk("R11 cnt", LOG_W'(cnt), 1);
    chk("R11 sts", LOG_W'(sts), 32'hC000);
    chk("R11 hdr", hdr_log, hdr_of(14));
    do_wr(32'h4000);
    chk("R7 last promote", LOG_W'(ptr), 15);
    chk("R7 last cnt", LOG_W'(cnt), 0);
    do_wr(32'h8000);
    chk("R8 final sts", LOG_W'(sts), 0);
    chk("R8 final ptr", LOG_W'(ptr), 0);

    finish_run();
  end
endmodule